// File: doc/BRIEF.md
# Watchdog Timer with Programmable External Reset Pulse

This block is a register-mapped watchdog for a 32-bit word bus. Software programs a reload value and a control word, then keeps the timer from expiring by writing a fixed key to the restart register. While counting is enabled, the counter steps down once for each cycle in which `tick_en` is high. A separate prescaler chooses how often that input pulses.

When the count runs out, the block does three things in the same clock edge. It reloads the counter. It raises one-cycle system-reset and interrupt requests, each gated by its own control bit. If external reset is enabled, it also starts a pulse on an external reset pin. Software sets the pin's active level and its drive style (push-pull, or open-drain modelled as an output enable) by writing key bytes into the top byte of the pulse-width register. Each write to that register also replaces the pulse-length field.

The timeout-status and timeout-clear words, the clock-source selection and the pad electrical behaviour are not modelled. The two status words read as zero and ignore writes. The clock-select bit and the reset-mode bit are stored and can be read back.

Top module: `watchdog_rstpulse`

## Requirements
- R1: After reset, the reload register reads 0x03EF1480, the counter (status, offset 0x00) reads 0x03EF1480, control reads 0, the pulse-width register reads 0x000000FF and restart reads 0. In that state `sys_rst_req`, `irq`, `ext_rst_o` and `ext_rst_oe` are all 0.
- R2: The byte offsets are 0x00 status, 0x04 reload, 0x08 restart, 0x0C control, 0x10 timeout status, 0x14 timeout clear and 0x18 pulse width. Offsets 0x08, 0x10 and 0x14 always read 0, and writes to 0x10 and 0x14 change nothing.
- R3: Writing exactly 0x00004755 to offset 0x08 loads the counter from the reload register. Any other value written there leaves the counter unchanged.
- R4: The counter decrements by one on each cycle where `tick_en` is high and control bit 0 is set. It holds when either of them is low.
- R5: A counted tick that finds the counter at 1 or 0 is an expiry. On that clock edge the counter reloads, `sys_rst_req` goes high for one cycle if control bit 1 is set, and `irq` goes high for one cycle if control bit 2 is set.
- R6: On a write to offset 0x18, data bits 31:24 act as a key. 0xA5 sets bit 31 (pulse active-high) and 0x5A clears it. 0xA8 sets bit 30 (push-pull) and 0x8A clears it (open-drain). Any other key leaves bits 31 and 30 unchanged.
- R7: Every write to offset 0x18 replaces the duration field, bits 19:0, with the write data, whatever the key. Bits 29:20 read 0.
- R8: An expiry starts the external pulse only when control bit 3 is set. The pulse lasts as many clock cycles as the duration field, and a field value of 0 counts as 1 cycle.
- R9: In push-pull mode, `ext_rst_oe` stays at 1. `ext_rst_o` shows the active level (bit 31) during the pulse and the opposite level otherwise.
- R10: In open-drain mode, `ext_rst_oe` is 1 only during the pulse, and `ext_rst_o` holds the active level at all times.
- R11: Control bits 5:0 (enable, system reset, interrupt, external reset, clock select, reset mode) are stored and read back. Control bits 31:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe from the time base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is returned one cycle later |
| bus_addr | input | 5 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry |
| irq | output | 1 | One-cycle interrupt on expiry |
| ext_rst_o | output | 1 | External reset pin level |
| ext_rst_oe | output | 1 | External reset pin output enable |

## Verification
The countdown is tested in several ways:
- with the enable bit clear, to show the counter holds;
- with the enable bit set and sparse ticks, to show the decrement rate;
- through an expiry with both requests enabled and then with both disabled, to show that each control bit gates its own output.

The pulse-width key decoder gets all four keys plus one unknown key, with a different duration each time, to show that the mode bits and the duration field are updated independently. The external pulse is measured by counting cycles in four cases, which together cover the zero-duration rule and the difference between the two drive styles:
- push-pull, active-low, length 5;
- push-pull, active-high, length 0;
- open-drain, active-high;
- external reset disabled.

// File: rtl/wdt_rp_pkg.sv
package wdt_rp_pkg;

  // Byte offsets of the word registers
  localparam int OFF_STATUS  = 'h00;
  localparam int OFF_RELOAD  = 'h04;
  localparam int OFF_RESTART = 'h08;
  localparam int OFF_CTRL    = 'h0C;
  localparam int OFF_TSTAT   = 'h10;
  localparam int OFF_TCLR    = 'h14;
  localparam int OFF_WIDTH   = 'h18;

  localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

  // Key bytes in bits 31:24 of a pulse-width write
  localparam logic [7:0] KEY_POL_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW   = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

  localparam int CTRL_W       = 6;
  localparam int CB_EN        = 0;
  localparam int CB_SYS_RST   = 1;
  localparam int CB_IRQ       = 2;
  localparam int CB_EXT_RST   = 3;
  localparam int CB_CLK_SEL   = 4;
  localparam int CB_FULL_CHIP = 5;

  localparam int WB_POL = 31;
  localparam int WB_PP  = 30;

endpackage

// File: rtl/wdt_rp_regs.sv
module wdt_rp_regs
  import wdt_rp_pkg::*;
#(
  parameter int          ADDR_W     = 5,
  parameter int          CNT_W      = 32,
  parameter int          DUR_W      = 20,
  parameter logic [31:0] RELOAD_RST = 32'h03EF_1480,
  parameter logic [31:0] DUR_RST    = 32'h0000_00FF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [CNT_W-1:0]   cnt_val,
  output logic [31:0]        bus_rdata,
  output logic [CNT_W-1:0]   reload_q,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic               pol_q,
  output logic               pp_q,
  output logic [DUR_W-1:0]   dur_q,
  output logic               restart_hit
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              wr_reload, wr_ctrl, wr_width;
  logic [7:0]        key;
  logic [31:0]       rd_mux;

  assign word_idx  = bus_addr[ADDR_W-1:2];
  assign key       = bus_wdata[31:24];
  assign wr_reload = bus_wr && (word_idx == WORD_W'(OFF_RELOAD / 4));
  assign wr_ctrl   = bus_wr && (word_idx == WORD_W'(OFF_CTRL / 4));
  assign wr_width  = bus_wr && (word_idx == WORD_W'(OFF_WIDTH / 4));
  assign restart_hit = bus_wr && (word_idx == WORD_W'(OFF_RESTART / 4))
                       && (bus_wdata == RESTART_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= CNT_W'(RELOAD_RST);
      ctrl_q   <= '0;
      pol_q    <= 1'b0;
      pp_q     <= 1'b0;
      dur_q    <= DUR_W'(DUR_RST);
    end else begin
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl)   ctrl_q   <= bus_wdata[CTRL_W-1:0];
      if (wr_width) begin
        dur_q <= bus_wdata[DUR_W-1:0];
        case (key)
          KEY_POL_HIGH:  pol_q <= 1'b1;
          KEY_POL_LOW:   pol_q <= 1'b0;
          KEY_PUSH_PULL: pp_q  <= 1'b1;
          KEY_OPEN_DRN:  pp_q  <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (word_idx)
      WORD_W'(OFF_STATUS / 4): rd_mux = 32'(cnt_val);
      WORD_W'(OFF_RELOAD / 4): rd_mux = 32'(reload_q);
      WORD_W'(OFF_CTRL / 4):   rd_mux = 32'(ctrl_q);
      WORD_W'(OFF_WIDTH / 4): begin
        rd_mux[WB_POL]      = pol_q;
        rd_mux[WB_PP]       = pp_q;
        rd_mux[DUR_W-1:0]   = dur_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/wdt_rp_counter.sv
module wdt_rp_counter #(
  parameter int          CNT_W      = 32,
  parameter logic [31:0] RELOAD_RST = 32'h03EF_1480
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             enable,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  logic counted;

  assign counted = enable && tick_en && !restart;
  assign expire  = counted && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= CNT_W'(RELOAD_RST);
    else if (restart || expire) cnt_q <= reload;
    else if (counted)           cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/wdt_rp_pulse.sv
module wdt_rp_pulse #(
  parameter int DUR_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [DUR_W-1:0] dur,
  input  logic             pol,
  input  logic             pp,
  output logic             ext_o,
  output logic             ext_oe
);

  logic [DUR_W-1:0] rem_q;
  logic [DUR_W-1:0] load_len;
  logic             act_n;

  assign load_len = (dur == '0) ? DUR_W'(1) : dur;
  assign act_n    = fire || (rem_q > DUR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      ext_o  <= 1'b0;
      ext_oe <= 1'b0;
    end else begin
      if (fire)              rem_q <= load_len;
      else if (rem_q != '0)  rem_q <= rem_q - DUR_W'(1);
      ext_o  <= pp ? (act_n ? pol : ~pol) : pol;
      ext_oe <= pp | act_n;
    end
  end

endmodule

// File: rtl/watchdog_rstpulse.sv
module watchdog_rstpulse
  import wdt_rp_pkg::*;
#(
  parameter int          ADDR_W     = 5,
  parameter int          CNT_W      = 32,
  parameter int          DUR_W      = 20,
  parameter logic [31:0] RELOAD_RST = 32'h03EF_1480,
  parameter logic [31:0] DUR_RST    = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req,
  output logic              irq,
  output logic              ext_rst_o,
  output logic              ext_rst_oe
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              pol_q, pp_q;
  logic [DUR_W-1:0]  dur_q;
  logic              restart_hit;
  logic              expire;

  wdt_rp_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUR_W(DUR_W),
    .RELOAD_RST(RELOAD_RST), .DUR_RST(DUR_RST)
  ) i_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt_q),
    .bus_rdata(bus_rdata), .reload_q(reload_q), .ctrl_q(ctrl_q),
    .pol_q(pol_q), .pp_q(pp_q), .dur_q(dur_q), .restart_hit(restart_hit)
  );

  wdt_rp_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) i_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .enable(ctrl_q[CB_EN]),
    .restart(restart_hit), .reload(reload_q), .cnt_q(cnt_q), .expire(expire)
  );

  wdt_rp_pulse #(.DUR_W(DUR_W)) i_pulse (
    .clk(clk), .rst(rst), .fire(expire && ctrl_q[CB_EXT_RST]),
    .dur(dur_q), .pol(pol_q), .pp(pp_q),
    .ext_o(ext_rst_o), .ext_oe(ext_rst_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_req <= 1'b0;
      irq         <= 1'b0;
    end else begin
      sys_rst_req <= expire && ctrl_q[CB_SYS_RST];
      irq         <= expire && ctrl_q[CB_IRQ];
    end
  end

endmodule

// File: rtl/wdt_rp_chk.sv
module wdt_rp_chk
  import wdt_rp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              restart_hit,
  input logic              expire,
  input logic              pol_q,
  input logic              pp_q,
  input logic              sys_rst_req,
  input logic              irq,
  input logic              ext_rst_o,
  input logic              ext_rst_oe
);

  // R3
  restart_loads_chk: assert property (@(posedge clk) disable iff (rst)
    restart_hit |=> (cnt_q == $past(reload_q)));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CB_EN] && !restart_hit) |=> (cnt_q == $past(cnt_q)));

  // R5
  expire_reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == $past(reload_q)));

  // R5
  rst_req_gated_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> ($past(ctrl_q[CB_SYS_RST]) && $past(expire)));

  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ctrl_q[CB_IRQ]) && $past(expire)));

  // R9
  push_pull_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pp_q)) |-> ext_rst_oe);

  // R10
  open_drain_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pp_q)) |-> (ext_rst_o == $past(pol_q)));

endmodule

bind watchdog_rstpulse wdt_rp_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .cnt_q(cnt_q), .reload_q(reload_q),
  .ctrl_q(ctrl_q), .restart_hit(restart_hit), .expire(expire),
  .pol_q(pol_q), .pp_q(pp_q), .sys_rst_req(sys_rst_req), .irq(irq),
  .ext_rst_o(ext_rst_o), .ext_rst_oe(ext_rst_oe)
);

// File: tb/test_watchdog_rstpulse.sv
module test_watchdog_rstpulse;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req, irq, ext_rst_o, ext_rst_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  watchdog_rstpulse i_watchdog_rstpulse (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .irq(irq), .ext_rst_o(ext_rst_o),
    .ext_rst_oe(ext_rst_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  // counts cycles (starting now) where the chosen pin equals val
  task automatic count_pin(input bit use_oe, input logic val, output int n);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if ((use_oe ? ext_rst_oe : ext_rst_o) === val) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 sys_rst_req", 32'(sys_rst_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ext_rst_o", 32'(ext_rst_o), 0);
    chk("R1 ext_rst_oe", 32'(ext_rst_oe), 0);
    rd(5'h00, d); chk("R1 status", d, 32'h03EF1480);
    rd(5'h04, d); chk("R1 reload", d, 32'h03EF1480);
    rd(5'h0C, d); chk("R1 ctrl", d, 0);
    rd(5'h18, d); chk("R1 width", d, 32'h000000FF);
    rd(5'h08, d); chk("R1 restart", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(5'h04, 32'h10); rd(5'h04, d); chk("R2 reload rw", d, 32'h10);
    wr(5'h10, 32'hFFFFFFFF); rd(5'h10, d); chk("R2 tstat", d, 0);
    wr(5'h14, 32'hFFFFFFFF); rd(5'h14, d); chk("R2 tclr", d, 0);
    rd(5'h04, d); chk("R2 reload untouched", d, 32'h10);
    rd(5'h18, d); chk("R2 width untouched", d, 32'hFF);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(5'h0C, 32'hFFFFFFFF); rd(5'h0C, d); chk("R11 ctrl bits", d, 32'h3F);
    wr(5'h0C, 32'h0);        rd(5'h0C, d); chk("R11 ctrl clear", d, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(5'h08, 32'h4756); rd(5'h00, d); chk("R3 bad key", d, 32'h03EF1480);
    wr(5'h08, 32'h4755); rd(5'h00, d); chk("R3 good key", d, 32'h10);
  endtask

  task automatic t_count();
    logic [31:0] d;
    tick(); tick(); rd(5'h00, d); chk("R4 hold disabled", d, 32'h10);
    wr(5'h0C, 32'h1);
    tick(); tick(); tick();
    rd(5'h00, d); chk("R4 decrement", d, 32'h0D);
    repeat (4) @(negedge clk);
    rd(5'h00, d); chk("R4 hold no tick", d, 32'h0D);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    wr(5'h04, 32'h2); wr(5'h08, 32'h4755); wr(5'h0C, 32'h7);
    tick();
    chk("R5 no early req", 32'(sys_rst_req), 0);
    tick();
    chk("R5 sys_rst_req", 32'(sys_rst_req), 1);
    chk("R5 irq", 32'(irq), 1);
    @(negedge clk);
    chk("R5 req one cycle", 32'(sys_rst_req), 0);
    chk("R5 irq one cycle", 32'(irq), 0);
    rd(5'h00, d); chk("R5 reloaded", d, 32'h2);
    wr(5'h0C, 32'h1);
    tick(); tick();
    chk("R5 req gated", 32'(sys_rst_req), 0);
    chk("R5 irq gated", 32'(irq), 0);
    rd(5'h00, d); chk("R5 reload when gated", d, 32'h2);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(5'h18, 32'hA5000010); rd(5'h18, d); chk("R6 pol high", d, 32'h80000010);
    wr(5'h18, 32'hA8000011); rd(5'h18, d); chk("R6 push-pull", d, 32'hC0000011);
    wr(5'h18, 32'h12345678); rd(5'h18, d); chk("R7 other key", d, 32'hC0045678);
    wr(5'h18, 32'h5A000001); rd(5'h18, d); chk("R6 pol low", d, 32'h40000001);
    wr(5'h18, 32'h8A000002); rd(5'h18, d); chk("R6 open-drain", d, 32'h00000002);
  endtask

  task automatic t_pulse_pp();
    int n;
    wr(5'h04, 32'h1); wr(5'h08, 32'h4755); wr(5'h0C, 32'h9);
    wr(5'h18, 32'hA8000005);
    @(negedge clk);
    chk("R9 idle level low-active", 32'(ext_rst_o), 1);
    tick();
    count_pin(1'b0, 1'b0, n); chk("R8 length 5", 32'(n), 5);
    count_pin(1'b1, 1'b1, n); chk("R9 oe held", 32'(n), 20);
    wr(5'h18, 32'hA5000000);
    @(negedge clk);
    chk("R9 idle level high-active", 32'(ext_rst_o), 0);
    tick();
    count_pin(1'b0, 1'b1, n); chk("R8 zero means one", 32'(n), 1);
  endtask

  task automatic t_pulse_od();
    int n;
    wr(5'h18, 32'h8A000003); wr(5'h18, 32'hA5000003);
    @(negedge clk);
    chk("R10 oe idle", 32'(ext_rst_oe), 0);
    tick();
    count_pin(1'b1, 1'b1, n); chk("R10 oe length", 32'(n), 3);
    count_pin(1'b0, 1'b1, n); chk("R10 level held", 32'(n), 20);
  endtask

  task automatic t_no_ext();
    int n;
    wr(5'h0C, 32'h1);
    tick();
    count_pin(1'b1, 1'b1, n); chk("R8 no pulse without enable", 32'(n), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_ctrl();
    t_restart();
    t_count();
    t_expire();
    t_keys();
    t_pulse_pp();
    t_pulse_od();
    t_no_ext();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule